// File: doc/BRIEF.md
# Paged Address Mapper with Access Protection

This block turns a 15-bit logical word address into a 20-bit physical word address. The upper five bits of the logical address pick one entry of a page table. The entry's 10-bit physical page is put in front of the 10-bit in-page offset, which is passed through unchanged. Four page tables are held side by side: one for the supervisor, one for the user program, and one for each of two I/O transfer channels. Every requester names the table it uses on `acc_map`. Tables are loaded one entry per clock through a write port. A separate combinational port reads any entry back.

Two protection mechanisms guard the address space. A programmable boundary register refuses user-table writes that fall below it. When translation and protection are both on, each page entry also carries a read-protect bit and a write-protect bit. A refused access has `acc_grant` held low. A two-state interrupt machine then latches the event on `irq`. Its state IDLE moves to PEND on transition `on_violation`, which is any refused access. PEND moves back to IDLE on transition `on_ack`, when `irq_ack` is high and the same cycle holds no new violation. Otherwise each state holds.

Top module: `pgmap_top`

## Requirements
- R1: With `map_en` high, `acc_paddr` equals {entry[9:0], acc_laddr[9:0]}, where the entry is the one indexed by acc_laddr[14:10] in the selected table; the result appears in the same cycle.
- R2: The four tables are independent and selected by `acc_map`: 0 supervisor, 1 user, 2 channel A, 3 channel B.
- R3: An entry is 12 bits: bit 11 read-protect, bit 10 write-protect, bits 9:0 physical page. A load with `ld_we` writes table `ld_map`, index `ld_idx`. The new value is visible on `rd_data` and in translation from the next cycle. In the load cycle the old value is still seen. `rd_data` returns entry (`rd_map`,`rd_idx`) combinationally.
- R4: With `map_en` low, `acc_paddr` is `acc_laddr` zero-extended to 20 bits, and the per-page protect bits are ignored.
- R5: With `prot_en` high, a user-table (`acc_map`=1) write whose logical address is below the boundary is refused. A write at or above the boundary is granted. Reads are never boundary-checked.
- R6: Accesses through tables 0, 2 and 3 are never boundary-checked.
- R7: With `map_en` and `prot_en` both high, a read to a page whose read-protect bit is set is refused. A write to a page whose write-protect bit is set is refused. With `prot_en` low, both are granted.
- R8: `acc_grant` is high only for a valid access that is not refused; with `acc_valid` low it is low.
- R9: `irq` rises in the cycle after a refused access. It stays high until a cycle with `irq_ack` high and no refused access. An `irq_ack` while `irq` is low has no effect.
- R10: After reset every entry of every table is zero, the boundary is zero and `irq` is low.
- R11: `fence_we` loads `fence_wdata` into the boundary register. An access in the load cycle is checked against the old boundary, and the new one applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| map_en | input | 1 | Translation on |
| prot_en | input | 1 | Protection on |
| fence_we | input | 1 | Load protection boundary |
| fence_wdata | input | 15 | New boundary (logical address) |
| ld_we | input | 1 | Load one table entry |
| ld_map | input | 2 | Table to load |
| ld_idx | input | 5 | Entry index to load |
| ld_data | input | 12 | Entry value {rp, wp, page} |
| rd_map | input | 2 | Table to read back |
| rd_idx | input | 5 | Entry index to read back |
| rd_data | output | 12 | Entry read back |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | Access is a write |
| acc_map | input | 2 | Table used by the access |
| acc_laddr | input | 15 | Logical word address |
| acc_paddr | output | 20 | Physical word address |
| acc_grant | output | 1 | Access allowed |
| irq | output | 1 | Protection violation pending |
| irq_ack | input | 1 | Acknowledge the violation |

## Verification
Translation, `rd_data` and `acc_grant` are combinational, so they are due in the same cycle as their stimulus. Table loads and boundary loads show their effect one cycle later. `irq` follows a refused access by exactly one cycle. The driver applies each stimulus at a falling edge. It computes what the outputs must show before the next rising edge from a model built on the requirements, and queues that expectation. The monitor pops the queue 3 ns after the same falling edge. Load-cycle and next-cycle effects therefore land in consecutive queued items, and the model's interrupt state moves one item later than the access that caused it.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
    localparam int LPAGE_W = 5;
    localparam int OFF_W   = 10;
    localparam int PPAGE_W = 10;
    localparam int NMAPS   = 4;
    localparam int LADDR_W = LPAGE_W + OFF_W;
    localparam int PADDR_W = PPAGE_W + OFF_W;
    localparam int NENT    = 1 << LPAGE_W;
    localparam int MSEL_W  = $clog2(NMAPS);
    localparam int ENT_W   = PPAGE_W + 2;

    typedef struct packed {
        logic               rd_prot;
        logic               wr_prot;
        logic [PPAGE_W-1:0] ppage;
    } map_ent_t;

    typedef enum logic [MSEL_W-1:0] {
        MAP_SYS = 2'd0,
        MAP_USR = 2'd1,
        MAP_CHA = 2'd2,
        MAP_CHB = 2'd3
    } map_sel_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/pgmap_bank.sv
module pgmap_bank
    import pgmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [MSEL_W-1:0]   wsel,
    input  logic [LPAGE_W-1:0]  widx,
    input  map_ent_t            wdata,
    input  logic [MSEL_W-1:0]   tsel,
    input  logic [LPAGE_W-1:0]  tidx,
    output map_ent_t            tent,
    input  logic [MSEL_W-1:0]   rsel,
    input  logic [LPAGE_W-1:0]  ridx,
    output map_ent_t            rent
);
    map_ent_t tab_q [NMAPS][NENT];
    map_ent_t t_row [NMAPS];
    map_ent_t r_row [NMAPS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < NMAPS; m++) begin
                for (int i = 0; i < NENT; i++) begin
                    tab_q[m][i] <= '0;
                end
            end
        end else if (we) begin
            tab_q[wsel][widx] <= wdata;
        end
    end

    for (genvar m = 0; m < NMAPS; m++) begin : g_row
        assign t_row[m] = tab_q[m][tidx];
        assign r_row[m] = tab_q[m][ridx];
    end

    assign tent = t_row[tsel];
    assign rent = r_row[rsel];
endmodule

// File: rtl/pgmap_guard.sv
module pgmap_guard
    import pgmap_pkg::*;
(
    input  logic               map_en,
    input  logic               prot_en,
    input  logic               valid,
    input  logic               write,
    input  logic [MSEL_W-1:0]  sel,
    input  logic [LADDR_W-1:0] laddr,
    input  logic [LADDR_W-1:0] fence,
    input  map_ent_t           ent,
    output logic [PADDR_W-1:0] paddr,
    output logic               grant,
    output logic               viol
);
    logic below_fence;
    logic fence_hit;
    logic page_hit;

    always_comb begin
        if (map_en) begin
            paddr = {ent.ppage, laddr[OFF_W-1:0]};
        end else begin
            paddr = PADDR_W'(laddr);
        end
    end

    always_comb begin
        below_fence = (laddr < fence);
        fence_hit   = prot_en && write && (sel == MAP_USR) && below_fence;
        page_hit    = map_en && prot_en && (write ? ent.wr_prot : ent.rd_prot);
        viol        = valid && (fence_hit || page_hit);
        grant       = valid && !(fence_hit || page_hit);
    end
endmodule

// File: rtl/pgmap_irq_fsm.sv
module pgmap_irq_fsm
    import pgmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic viol,
    input  logic ack,
    output logic irq
);
    irq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= IRQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: if (viol)         st_d = IRQ_PEND;
            IRQ_PEND: if (ack && !viol) st_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (st_q == IRQ_PEND);
    end
endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import pgmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_en,
    input  logic               prot_en,
    input  logic               fence_we,
    input  logic [LADDR_W-1:0] fence_wdata,
    input  logic               ld_we,
    input  logic [MSEL_W-1:0]  ld_map,
    input  logic [LPAGE_W-1:0] ld_idx,
    input  logic [ENT_W-1:0]   ld_data,
    input  logic [MSEL_W-1:0]  rd_map,
    input  logic [LPAGE_W-1:0] rd_idx,
    output logic [ENT_W-1:0]   rd_data,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [MSEL_W-1:0]  acc_map,
    input  logic [LADDR_W-1:0] acc_laddr,
    output logic [PADDR_W-1:0] acc_paddr,
    output logic               acc_grant,
    output logic               irq,
    input  logic               irq_ack
);
    logic [LADDR_W-1:0] fence_q;
    map_ent_t           t_ent;
    map_ent_t           r_ent;
    logic               viol;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fence_q <= '0;
        end else if (fence_we) begin
            fence_q <= fence_wdata;
        end
    end

    pgmap_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_we),
        .wsel  (ld_map),
        .widx  (ld_idx),
        .wdata (map_ent_t'(ld_data)),
        .tsel  (acc_map),
        .tidx  (acc_laddr[LADDR_W-1:OFF_W]),
        .tent  (t_ent),
        .rsel  (rd_map),
        .ridx  (rd_idx),
        .rent  (r_ent)
    );

    assign rd_data = r_ent;

    pgmap_guard u_guard (
        .map_en  (map_en),
        .prot_en (prot_en),
        .valid   (acc_valid),
        .write   (acc_write),
        .sel     (acc_map),
        .laddr   (acc_laddr),
        .fence   (fence_q),
        .ent     (t_ent),
        .paddr   (acc_paddr),
        .grant   (acc_grant),
        .viol    (viol)
    );

    pgmap_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .viol  (viol),
        .ack   (irq_ack),
        .irq   (irq)
    );
endmodule

// File: rtl/pgmap_chk.sv
module pgmap_chk
    import pgmap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               map_en,
    input logic               prot_en,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [MSEL_W-1:0]  acc_map,
    input logic [LADDR_W-1:0] acc_laddr,
    input logic [PADDR_W-1:0] acc_paddr,
    input logic               acc_grant,
    input logic               irq,
    input logic               irq_ack,
    input logic [LADDR_W-1:0] fence_q
);
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> acc_paddr[OFF_W-1:0] == acc_laddr[OFF_W-1:0]);

    assert_flat_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en |-> acc_paddr[PADDR_W-1:LADDR_W] == '0);

    assert_flat_read_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !map_en && !acc_write) |-> acc_grant);

    assert_fence_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && acc_valid && acc_write && acc_map == MAP_USR && acc_laddr < fence_q)
        |-> !acc_grant);

    assert_no_fence_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !map_en && acc_map != MAP_USR) |-> acc_grant);

    assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_grant);

    assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_grant) |=> irq);

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && !(acc_valid && !acc_grant)) |=> !irq);

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(acc_valid && !acc_grant));
endmodule

bind pgmap_top pgmap_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_en    (map_en),
    .prot_en   (prot_en),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_map   (acc_map),
    .acc_laddr (acc_laddr),
    .acc_paddr (acc_paddr),
    .acc_grant (acc_grant),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .fence_q   (fence_q)
);

// File: tb/tb_pgmap_top.sv
module tb_pgmap_top;
    import pgmap_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               map_en, prot_en, fence_we, ld_we, acc_valid, acc_write, irq_ack;
    logic [LADDR_W-1:0] fence_wdata, acc_laddr;
    logic [MSEL_W-1:0]  ld_map, rd_map, acc_map;
    logic [LPAGE_W-1:0] ld_idx, rd_idx;
    logic [ENT_W-1:0]   ld_data, rd_data;
    logic [PADDR_W-1:0] acc_paddr;
    logic               acc_grant, irq;

    always #4 clk = ~clk;

    pgmap_top dut (.*);

    typedef struct {
        string              tag;
        logic [PADDR_W-1:0] paddr;
        logic               grant;
        logic               irq;
        logic [ENT_W-1:0]   rd;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [ENT_W-1:0]   m_tab [NMAPS][NENT];
    logic [LADDR_W-1:0] m_fence;
    logic               m_irq;

    task automatic model_reset();
        for (int m = 0; m < NMAPS; m++)
            for (int i = 0; i < NENT; i++) m_tab[m][i] = '0;
        m_fence = '0;
        m_irq   = 1'b0;
    endtask

    // One cycle: expectation from current inputs, queue it, advance model, wait.
    task automatic tick(string tag);
        exp_t e;
        logic [ENT_W-1:0] ent;
        logic fhit, phit, viol;
        ent  = m_tab[acc_map][acc_laddr[LADDR_W-1:OFF_W]];
        fhit = prot_en && acc_write && acc_map == 2'd1 && acc_laddr < m_fence;
        phit = map_en && prot_en && (acc_write ? ent[10] : ent[11]);
        viol = acc_valid && (fhit || phit);
        e.tag   = tag;
        e.paddr = map_en ? {ent[PPAGE_W-1:0], acc_laddr[OFF_W-1:0]} : PADDR_W'(acc_laddr);
        e.grant = acc_valid && !(fhit || phit);
        e.irq   = m_irq;
        e.rd    = m_tab[rd_map][rd_idx];
        exp_q.push_back(e);
        if (ld_we) m_tab[ld_map][ld_idx] = ld_data;
        if (fence_we) m_fence = fence_wdata;
        m_irq = viol || (m_irq && !irq_ack);
        @(negedge clk);
        ld_we = 0; fence_we = 0; irq_ack = 0; acc_valid = 0; acc_write = 0;
    endtask

    task automatic acc(logic wr, logic [1:0] sel, logic [14:0] la);
        acc_valid = 1; acc_write = wr; acc_map = sel; acc_laddr = la;
    endtask

    task automatic load(logic [1:0] sel, logic [4:0] idx, logic [11:0] d);
        ld_we = 1; ld_map = sel; ld_idx = idx; ld_data = d;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Monitor: pops one expectation per cycle, 3 ns after the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "acc_paddr", 32'(acc_paddr), 32'(e.paddr));
                chk(e.tag, "acc_grant", 32'(acc_grant), 32'(e.grant));
                chk(e.tag, "irq", 32'(irq), 32'(e.irq));
                chk(e.tag, "rd_data", 32'(rd_data), 32'(e.rd));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; map_en = 0; prot_en = 0; fence_we = 0; fence_wdata = '0;
        ld_we = 0; ld_map = '0; ld_idx = '0; ld_data = '0; rd_map = '0; rd_idx = '0;
        acc_valid = 0; acc_write = 0; acc_map = '0; acc_laddr = '0; irq_ack = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10 reset contents
        rd_map = 0; rd_idx = 0;  tick("R10 entry zero");
        rd_map = 3; rd_idx = 31; tick("R10 entry zero");
        prot_en = 1; acc(1, 1, 15'h0000); tick("R10 R5 boundary zero");
        prot_en = 0;

        // R3 loads take effect next cycle
        rd_map = 0; rd_idx = 3;
        load(0, 3, 12'h155); tick("R3 old value in load cycle");
        load(1, 3, 12'h2AA); tick("R3 new value next cycle");
        rd_map = 1;
        load(2, 3, 12'h0F0); tick("R3 second table");
        load(3, 3, 12'h30F); rd_map = 2; tick("R3 third table");
        rd_map = 3; tick("R3 fourth table");

        // R1 R2 translation through each table
        map_en = 1;
        for (int k = 0; k < 4; k++) begin
            acc(0, 2'(k), 15'h0D23); tick("R1 R2 translate");
        end
        acc(1, 2, 15'h0FFF); tick("R1 offset top");
        acc(0, 0, 15'h1123); tick("R2 unloaded page");

        // R4 translation off
        map_en = 0;
        acc(0, 1, 15'h0D23); tick("R4 flat address");
        acc(0, 3, 15'h7FFF); tick("R4 flat top");

        // R11 boundary load timing, R5 boundary
        prot_en = 1;
        fence_we = 1; fence_wdata = 15'h2000; acc(1, 1, 15'h1FFF); tick("R11 old boundary in load cycle");
        acc(1, 1, 15'h1FFF); tick("R5 write below boundary");
        acc(1, 1, 15'h2000); tick("R5 write at boundary R9 irq set");
        acc(0, 1, 15'h0100); tick("R5 read below boundary");
        acc(1, 0, 15'h0100); tick("R6 supervisor write");
        acc(1, 2, 15'h0100); tick("R6 channel A write");
        acc(1, 3, 15'h0100); tick("R6 channel B write");
        tick("R8 idle no grant R9 hold");
        irq_ack = 1; tick("R9 ack");
        tick("R9 cleared");
        irq_ack = 1; tick("R9 ack while low ignored");
        tick("R9 still low");

        // R9 ack together with a new violation keeps irq
        acc(1, 1, 15'h0010); tick("R9 violation");
        irq_ack = 1; acc(1, 1, 15'h0020); tick("R9 ack with new violation");
        tick("R9 kept high");
        irq_ack = 1; tick("R9 ack alone");
        tick("R9 dropped");

        // R7 per-page protect bits
        load(1, 10, 12'h411); tick("R7 load write-protect page");
        load(0, 11, 12'h822); tick("R7 load read-protect page");
        map_en = 1;
        acc(1, 1, 15'h2805); tick("R7 write to write-protected page");
        acc(0, 1, 15'h2805); irq_ack = 1; tick("R7 read of write-protected page");
        acc(0, 0, 15'h2C05); tick("R7 read of read-protected page");
        acc(1, 0, 15'h2C05); irq_ack = 1; tick("R7 write to read-protected page");
        prot_en = 0;
        acc(1, 1, 15'h2805); tick("R7 protection off write");
        acc(0, 0, 15'h2C05); tick("R7 protection off read");
        map_en = 0; prot_en = 1;
        acc(0, 0, 15'h2C05); tick("R4 page bits ignored unmapped");
        acc(1, 1, 15'h2805); tick("R4 page bits ignored unmapped write");
        tick("R8 final idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule